// File: doc/BRIEF.md
# Real-Mode Segment Address Generator

This block forms the 20-bit physical byte address used by a processor that runs in a segmented real-address mode. It holds six 16-bit segment base registers. For each request it picks one of them from the kind of access, or from an explicit override. It places four zero bits below the chosen segment value and adds the 16-bit offset. Every segment therefore starts on a 16-byte boundary and spans exactly 64 KB.

An upstream decode stage presents a request: the access kind, the offset, and optionally an override index. The resulting address and the index of the register that was used appear one clock later, flagged by a valid bit. A separate synchronous port loads the segment registers.

Top module: `segaddr_gen`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `addr_valid`, `phys_addr` and `seg_used` clear to zero and all six segment registers clear to zero.
- R2: The address is `({seg, 4'h0} + offset)` taken to 20 bits. The low four address bits equal the low four offset bits. Segment 348AH with offset 4214H gives 38AB4H.
- R3: A carry out of bit 19 is dropped. Segment FFFFH with offset 0010H gives 00000H.
- R4: `addr_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. On cycles without a request, `phys_addr` and `seg_used` hold their values.
- R5: `req_kind` encodes 0 = instruction fetch, 1 = data, 2 = stack, 3 = string destination. Without an override these select register indices 0 (code), 1 (data), 2 (stack) and 3 (extra). `seg_used` reports the index that was used. Indices 4 and 5 are never chosen by default.
- R6: For kinds 1 to 3, `ovr_valid` with `ovr_sel` in 0..5 selects register `ovr_sel`.
- R7: For an instruction fetch the override is ignored and register 0 is always used.
- R8: An override with `ovr_sel` of 6 or 7 is ignored, and the default register is used.
- R9: With `wr_en` high, `wr_data` is loaded into register `wr_idx` at the clock edge. A request in that same cycle uses the register's previous value.
- R10: A write with `wr_idx` of 6 or 7 changes no segment register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind (0 fetch, 1 data, 2 stack, 3 string destination) |
| ovr_valid | input | 1 | Override select present |
| ovr_sel | input | 3 | Override register index |
| req_offset | input | 16 | Offset within the segment |
| wr_en | input | 1 | Segment register write strobe |
| wr_idx | input | 3 | Register index to write |
| wr_data | input | 16 | Segment value to write |
| phys_addr | output | 20 | Registered physical address |
| seg_used | output | 3 | Index of the register that was used |
| addr_valid | output | 1 | `phys_addr` and `seg_used` are new this cycle |

## Verification
The hardest case to reach is a write and a request that name the same register in the same cycle. This is where the read-before-write ordering shows. The random stream only lines up a write index with the selected register now and then. A directed step therefore writes the stack register while a stack request is in flight, then repeats the request and expects the new value. The dropped carry also needs specific operands, so the random stream is backed by a directed FFFFH:0010H case and the 348AH:4214H case. Writes to the unused indices 6 and 7 are checked by reading all six registers back through overrides at offset zero.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

   typedef enum logic [1:0] {
      KIND_FETCH  = 2'd0,
      KIND_DATA   = 2'd1,
      KIND_STACK  = 2'd2,
      KIND_STRDST = 2'd3
   } acc_kind_t;

   localparam int unsigned IDX_CODE  = 0;
   localparam int unsigned IDX_DATA  = 1;
   localparam int unsigned IDX_STACK = 2;
   localparam int unsigned IDX_EXTRA = 3;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned NSEG  = 6,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [SEG_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [SEG_W-1:0] rd_data
);

   logic [SEG_W-1:0] seg_q [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            seg_q[g] <= '0;
         end else if (wr_en && (wr_idx == MY_IDX)) begin
            seg_q[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NSEG; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_data = seg_q[i];
         end
      end
   end

endmodule

// File: rtl/seg_select.sv
module seg_select
   import segaddr_pkg::*;
#(
   parameter int unsigned NSEG  = 6,
   parameter int unsigned IDX_W = 3
) (
   input  acc_kind_t        kind,
   input  logic             ovr_valid,
   input  logic [IDX_W-1:0] ovr_sel,
   output logic [IDX_W-1:0] sel_idx
);

   localparam logic [IDX_W:0] NSEG_V = (IDX_W+1)'(NSEG);

   logic [IDX_W-1:0] dflt_idx;
   logic             ovr_ok;

   always_comb begin
      unique case (kind)
         KIND_FETCH:  dflt_idx = IDX_W'(IDX_CODE);
         KIND_DATA:   dflt_idx = IDX_W'(IDX_DATA);
         KIND_STACK:  dflt_idx = IDX_W'(IDX_STACK);
         KIND_STRDST: dflt_idx = IDX_W'(IDX_EXTRA);
         default:     dflt_idx = IDX_W'(IDX_CODE);
      endcase
   end

   assign ovr_ok  = ovr_valid && ({1'b0, ovr_sel} < NSEG_V) && (kind != KIND_FETCH);
   assign sel_idx = ovr_ok ? ovr_sel : dflt_idx;

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SHIFT     = 4,
   parameter bit          SPLIT_ADD = 1'b1,
   localparam int unsigned ADDR_W   = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);

   if (SPLIT_ADD && (OFF_W > SHIFT)) begin : g_split
      localparam int unsigned HI_W = OFF_W - SHIFT;
      logic [SEG_W-1:0] hi_sum;
      assign hi_sum = seg + SEG_W'(off[OFF_W-1:SHIFT]);
      assign addr   = {hi_sum, off[SHIFT-1:0]};
      if (HI_W > SEG_W) begin : g_bad_hi
         $error("seg_adder: offset upper part wider than segment");
      end
   end else begin : g_full
      assign addr = {seg, {SHIFT{1'b0}}} + ADDR_W'(off);
   end

endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
   import segaddr_pkg::*;
#(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SHIFT     = 4,
   parameter int unsigned NSEG      = 6,
   parameter int unsigned IDX_W     = 3,
   parameter bit          SPLIT_ADD = 1'b1,
   localparam int unsigned ADDR_W   = SEG_W + SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              ovr_valid,
   input  logic [IDX_W-1:0]  ovr_sel,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SEG_W-1:0]  wr_data,
   output logic [ADDR_W-1:0] phys_addr,
   output logic [IDX_W-1:0]  seg_used,
   output logic              addr_valid
);

   if (SHIFT < 1) begin : g_bad_shift
      $error("segaddr_gen: SHIFT must be at least 1");
   end
   if (NSEG < 4 || NSEG > (1 << IDX_W)) begin : g_bad_nseg
      $error("segaddr_gen: NSEG must cover the four defaults and fit IDX_W");
   end
   if (OFF_W > ADDR_W) begin : g_bad_off
      $error("segaddr_gen: offset wider than physical address");
   end

   logic [IDX_W-1:0]  sel_idx;
   logic [SEG_W-1:0]  sel_seg;
   logic [ADDR_W-1:0] sum_addr;

   seg_select #(
      .NSEG  (NSEG),
      .IDX_W (IDX_W)
   ) u_select (
      .kind      (acc_kind_t'(req_kind)),
      .ovr_valid (ovr_valid),
      .ovr_sel   (ovr_sel),
      .sel_idx   (sel_idx)
   );

   seg_regfile #(
      .SEG_W (SEG_W),
      .NSEG  (NSEG),
      .IDX_W (IDX_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (sel_idx),
      .rd_data (sel_seg)
   );

   seg_adder #(
      .SEG_W     (SEG_W),
      .OFF_W     (OFF_W),
      .SHIFT     (SHIFT),
      .SPLIT_ADD (SPLIT_ADD)
   ) u_add (
      .seg  (sel_seg),
      .off  (req_offset),
      .addr (sum_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_valid <= 1'b0;
         phys_addr  <= '0;
         seg_used   <= '0;
      end else begin
         addr_valid <= req_valid;
         if (req_valid) begin
            phys_addr <= sum_addr;
            seg_used  <= sel_idx;
         end
      end
   end

endmodule

// File: rtl/segaddr_chk.sv
module segaddr_chk #(
   parameter int unsigned OFF_W  = 16,
   parameter int unsigned SHIFT  = 4,
   parameter int unsigned NSEG   = 6,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_kind,
   input logic              ovr_valid,
   input logic [IDX_W-1:0]  ovr_sel,
   input logic [OFF_W-1:0]  req_offset,
   input logic [ADDR_W-1:0] phys_addr,
   input logic [IDX_W-1:0]  seg_used,
   input logic              addr_valid
);

   localparam logic [IDX_W:0] NSEG_V = (IDX_W+1)'(NSEG);

   logic sel_in_range;
   assign sel_in_range = ({1'b0, ovr_sel} < NSEG_V);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!addr_valid && phys_addr == '0 && seg_used == '0));

   // R4
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> addr_valid);

   // R4
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!addr_valid && $stable(phys_addr) && $stable(seg_used)));

   // R2
   low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (phys_addr[SHIFT-1:0] == $past(req_offset[SHIFT-1:0])));

   // R7
   fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd0) |=> (seg_used == '0));

   // R5
   default_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != 2'd0 && !ovr_valid) |=> (seg_used == IDX_W'($past(req_kind))));

   // R6
   override_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != 2'd0 && ovr_valid && sel_in_range) |=> (seg_used == $past(ovr_sel)));

   // R8
   bad_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != 2'd0 && ovr_valid && !sel_in_range) |=> (seg_used == IDX_W'($past(req_kind))));

   // R5
   used_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> ({1'b0, seg_used} < NSEG_V));

endmodule

bind segaddr_gen segaddr_chk #(
   .OFF_W  (OFF_W),
   .SHIFT  (SHIFT),
   .NSEG   (NSEG),
   .IDX_W  (IDX_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_kind   (req_kind),
   .ovr_valid  (ovr_valid),
   .ovr_sel    (ovr_sel),
   .req_offset (req_offset),
   .phys_addr  (phys_addr),
   .seg_used   (seg_used),
   .addr_valid (addr_valid)
);

// File: tb/tb_segaddr_gen.sv
module tb_segaddr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic        ovr_valid = 1'b0;
   logic [2:0]  ovr_sel = 3'd0;
   logic [15:0] req_offset = 16'h0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = 3'd0;
   logic [15:0] wr_data = 16'h0;
   logic [19:0] phys_addr;
   logic [2:0]  seg_used;
   logic        addr_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [15:0] mdl [6];
   logic [19:0] last_addr = '0;
   logic [2:0]  last_sel  = '0;

   always #10 clk = ~clk;

   segaddr_gen dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .req_offset(req_offset),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .phys_addr(phys_addr), .seg_used(seg_used), .addr_valid(addr_valid)
   );

   function automatic logic [2:0] exp_sel(input logic [1:0] k, input logic ov, input logic [2:0] s);
      if (k != 2'd0 && ov && s < 3'd6) return s;
      return {1'b0, k};
   endfunction

   function automatic logic [19:0] exp_addr(input logic [15:0] sg, input logic [15:0] of);
      logic [20:0] full;
      full = {1'b0, sg, 4'h0} + {5'h0, of};
      return full[19:0];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic string sel_tag(input logic [1:0] k, input logic ov, input logic [2:0] s);
      if (k == 2'd0) return ov ? "R7" : "R5";
      if (!ov) return "R5";
      return (s < 3'd6) ? "R6" : "R8";
   endfunction

   // One cycle: drive at negedge, let a posedge pass, check at the next negedge.
   task automatic step(input logic rv, input logic [1:0] k, input logic ov, input logic [2:0] s,
                       input logic [15:0] off, input logic we, input logic [2:0] wi,
                       input logic [15:0] wd, input string atag);
      logic [2:0]  es;
      logic [19:0] ea;
      req_valid = rv; req_kind = k; ovr_valid = ov; ovr_sel = s; req_offset = off;
      wr_en = we; wr_idx = wi; wr_data = wd;
      es = exp_sel(k, ov, s);
      ea = exp_addr(mdl[es], off);
      @(posedge clk);
      if (we && wi < 3'd6) mdl[wi] = wd;
      @(negedge clk);
      check("R4 valid", {31'b0, addr_valid}, {31'b0, rv});
      if (rv) begin
         check(sel_tag(k, ov, s), {29'b0, seg_used}, {29'b0, es});
         check(atag, {12'b0, phys_addr}, {12'b0, ea});
         last_addr = ea; last_sel = es;
      end else begin
         check("R4 hold addr", {12'b0, phys_addr}, {12'b0, last_addr});
         check("R4 hold sel", {29'b0, seg_used}, {29'b0, last_sel});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      for (int i = 0; i < 6; i++) mdl[i] = 16'h0;
      repeat (3) @(negedge clk);
      // R1: outputs clear in reset
      check("R1 valid", {31'b0, addr_valid}, 32'd0);
      check("R1 addr", {12'b0, phys_addr}, 32'd0);
      check("R1 sel", {29'b0, seg_used}, 32'd0);
      rst_n = 1'b1;
      // R1: every register reads as zero
      for (int i = 0; i < 6; i++) step(1, 2'd1, 1, 3'(i), 16'h0, 0, 0, 0, "R1 reg zero");

      // R2: known example
      step(0, 0, 0, 0, 0, 1, 3'd0, 16'h348A, "R9");
      step(1, 2'd0, 0, 0, 16'h4214, 0, 0, 0, "R2");
      check("R2 literal", {12'b0, phys_addr}, 32'h38AB4);

      // R3: carry dropped
      step(0, 0, 0, 0, 0, 1, 3'd1, 16'hFFFF, "R9");
      step(1, 2'd1, 0, 0, 16'h0010, 0, 0, 0, "R3");
      check("R3 literal", {12'b0, phys_addr}, 32'h00000);

      // R7: fetch ignores override
      step(1, 2'd0, 1, 3'd4, 16'h0001, 0, 0, 0, "R7");
      check("R7 code", {29'b0, seg_used}, 32'd0);

      // R8: out-of-range overrides
      step(1, 2'd1, 1, 3'd6, 16'h0002, 0, 0, 0, "R8");
      check("R8 sel6", {29'b0, seg_used}, 32'd1);
      step(1, 2'd2, 1, 3'd7, 16'h0003, 0, 0, 0, "R8");
      check("R8 sel7", {29'b0, seg_used}, 32'd2);

      // R6: reach the auxiliary registers
      step(0, 0, 0, 0, 0, 1, 3'd4, 16'h1111, "R9");
      step(0, 0, 0, 0, 0, 1, 3'd5, 16'h2222, "R9");
      step(1, 2'd3, 1, 3'd4, 16'h0005, 0, 0, 0, "R6");
      step(1, 2'd1, 1, 3'd5, 16'h0005, 0, 0, 0, "R6");

      // R10: writes to indices 6 and 7 touch nothing
      step(0, 0, 0, 0, 0, 1, 3'd6, 16'hAAAA, "R10");
      step(0, 0, 0, 0, 0, 1, 3'd7, 16'h5555, "R10");
      for (int i = 0; i < 6; i++) step(1, 2'd1, 1, 3'(i), 16'h0, 0, 0, 0, "R10 readback");

      // R9: same-cycle write and read uses old value
      step(1, 2'd2, 0, 0, 16'h0000, 1, 3'd2, 16'h1234, "R9 old value");
      step(1, 2'd2, 0, 0, 16'h0000, 0, 0, 0, "R9 new value");
      check("R9 literal", {12'b0, phys_addr}, 32'h12340);

      // R4: idle cycles hold the outputs
      step(0, 0, 0, 0, 0, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R4");

      // Random mix
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 4) != 0, 2'($urandom), ($urandom % 2) == 1, 3'($urandom),
              16'($urandom), ($urandom % 3) == 0, 3'($urandom), 16'($urandom), "R2 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule